// File: doc/BRIEF.md
# Flash Toggle-Bit Completion Poller

This block sits on the host side of a flash memory bus. It decides whether a program or erase operation has ended, and whether it ended well, by reading the device status word repeatedly. A toggle flag in the status word flips on every read while the device is busy. A timeout flag is raised when the device gives up. The block asks for each status word with a request/valid handshake. It compares the toggle flag across pairs of back-to-back reads and watches the timeout flag. On a failed operation it sends the device reset command as one write before it reports the result.

The toggle flag can stop at the same moment the timeout flag rises. For that reason, a set timeout flag never causes an immediate failure. The block first reads one more pair of status words to confirm. The system may abort polling at any point to do other work. The next start then runs the algorithm again from the first read of a new pair.

States are `S_IDLE`, `S_READ_A`, `S_READ_B`, `S_DECIDE`, `S_RESET_CMD` and `S_REPORT`. The transitions are as follows:
- start: `S_IDLE`→`S_READ_A`
- first word taken: `S_READ_A`→`S_READ_B`
- second word taken: `S_READ_B`→`S_DECIDE`
- steady: `S_DECIDE`→`S_REPORT`
- new pair or confirm pair: `S_DECIDE`→`S_READ_A`
- confirmed failure or limit reached: `S_DECIDE`→`S_RESET_CMD`
- reset write accepted: `S_RESET_CMD`→`S_REPORT`
- report: `S_REPORT`→`S_IDLE`
- abort: any state→`S_IDLE`

Top module: `toggle_poller`

## Requirements
- R1: A start pulse in idle makes the block read two status words back to back. `busy` stays high from the cycle after start until the cycle in which `done` is high, and it is low afterwards.
- R2: If bit 6 is equal in both words of a pair, the block pulses `done` with `pass` high. It issues no write and makes no further read.
- R3: If bit 6 differs and bit 5 of the second word of the pair is low, the block reads a new pair. Bit 5 of the first word has no effect on this decision.
- R4: If bit 6 differs and bit 5 of the second word is high, the block reads one confirming pair. If bit 6 is equal in that pair, it reports `pass`.
- R5: If bit 6 still differs in the confirming pair, the block writes 0xF0 on `wr_data` with `wr_req` held until `wr_ack`. Only after that write does it pulse `done` with `pass` low. `rd_req` and `wr_req` are never high together.
- R6: With `poll_limit` nonzero, the block ends with failure and the reset write after `poll_limit` pairs that toggle with bit 5 low. A `poll_limit` of 0 removes the limit.
- R7: An abort while busy returns the block to idle on the next cycle without `done`. The following start begins at the first read of a new pair and clears any pending confirmation.
- R8: `done` lasts exactly one cycle, and `pass` is high only together with `done`. After reset, `busy`, `done`, `pass`, `rd_req` and `wr_req` are low.
- R9: A read completes in a cycle where `rd_req` and `rd_valid` are both high. `rd_req` stays high until that happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin polling (acted on in idle) |
| abort | input | 1 | Abandon polling, return to idle |
| poll_limit | input | CNT_W | Toggling pairs allowed before failure, 0 = no limit |
| rd_req | output | 1 | Status read request |
| rd_valid | input | 1 | Status word present on rd_data |
| rd_data | input | STAT_W | Status word |
| wr_req | output | 1 | Reset-command write request |
| wr_data | output | STAT_W | Write data, 0xF0 during the reset write |
| wr_ack | input | 1 | Write accepted |
| busy | output | 1 | Polling in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Operation succeeded (valid with done) |

## Verification
The bench targets the confirming pair after bit 5 rises. A design that fails at once on the timeout flag would report failure where the expected result is pass, and it would read too few words. It feeds a pair whose first word carries bit 5 but whose second does not. A design that looks at the wrong word would stop polling early. It also aborts during a confirmation and restarts. A block that resumed mid-pair or kept the confirm flag would read the wrong number of words or fail a steady operation. Finally, it runs the pair limit on an endless toggle. A counter off by one would show up as one pair too many or too few.

// File: rtl/tp_pkg.sv
package tp_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_READ_A,
        S_READ_B,
        S_DECIDE,
        S_RESET_CMD,
        S_REPORT
    } tp_state_e;

    localparam logic [7:0] FLASH_RESET_CMD = 8'hF0;

endpackage

// File: rtl/tp_toggle_track.sv
module tp_toggle_track #(
    parameter int STAT_W  = 8,
    parameter int TOG_BIT = 6,
    parameter int TMO_BIT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_first,
    input  logic              cap_second,
    input  logic [STAT_W-1:0] word,
    output logic              toggled,
    output logic              timeout_seen
);

    logic ref_q;
    logic tog_q;
    logic tmo_q;

    // First word of a pair sets the reference; second word yields the verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q <= 1'b0;
            tog_q <= 1'b0;
            tmo_q <= 1'b0;
        end else begin
            if (cap_first) begin
                ref_q <= word[TOG_BIT];
            end
            if (cap_second) begin
                tog_q <= ref_q ^ word[TOG_BIT];
                tmo_q <= word[TMO_BIT];
            end
        end
    end

    assign toggled      = tog_q;
    assign timeout_seen = tmo_q;

endmodule

// File: rtl/tp_pair_cnt.sv
module tp_pair_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic [CNT_W-1:0] limit,
    output logic             last_pair
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   cnt_plus;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // True when the pair now being judged would reach the limit.
    assign cnt_plus  = {1'b0, cnt_q} + 1'b1;
    assign last_pair = (limit != '0) && (cnt_plus >= {1'b0, limit});

endmodule

// File: rtl/toggle_poller.sv
module toggle_poller
    import tp_pkg::*;
#(
    parameter int STAT_W  = 8,
    parameter int TOG_BIT = 6,
    parameter int TMO_BIT = 5,
    parameter int CNT_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic [CNT_W-1:0]  poll_limit,
    output logic              rd_req,
    input  logic              rd_valid,
    input  logic [STAT_W-1:0] rd_data,
    output logic              wr_req,
    output logic [STAT_W-1:0] wr_data,
    input  logic              wr_ack,
    output logic              busy,
    output logic              done,
    output logic              pass
);

    localparam logic [STAT_W-1:0] CMD_WORD = STAT_W'(FLASH_RESET_CMD);

    tp_state_e state_q, state_d;
    logic      confirm_q, confirm_d;
    logic      ok_q, ok_d;
    logic      cap_a, cap_b;
    logic      cnt_clr, cnt_inc;
    logic      toggled, timeout_seen, last_pair;

    tp_toggle_track #(
        .STAT_W (STAT_W),
        .TOG_BIT(TOG_BIT),
        .TMO_BIT(TMO_BIT)
    ) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_first   (cap_a),
        .cap_second  (cap_b),
        .word        (rd_data),
        .toggled     (toggled),
        .timeout_seen(timeout_seen)
    );

    tp_pair_cnt #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cnt_clr),
        .inc      (cnt_inc),
        .limit    (poll_limit),
        .last_pair(last_pair)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            confirm_q <= 1'b0;
            ok_q      <= 1'b0;
        end else begin
            state_q   <= state_d;
            confirm_q <= confirm_d;
            ok_q      <= ok_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d   = state_q;
        confirm_d = confirm_q;
        ok_d      = ok_q;
        cap_a     = 1'b0;
        cap_b     = 1'b0;
        cnt_clr   = 1'b0;
        cnt_inc   = 1'b0;
        if (abort) begin
            state_d = S_IDLE;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start) begin
                        state_d   = S_READ_A;
                        confirm_d = 1'b0;
                        ok_d      = 1'b0;
                        cnt_clr   = 1'b1;
                    end
                end
                S_READ_A: begin
                    if (rd_valid) begin
                        cap_a   = 1'b1;
                        state_d = S_READ_B;
                    end
                end
                S_READ_B: begin
                    if (rd_valid) begin
                        cap_b   = 1'b1;
                        state_d = S_DECIDE;
                    end
                end
                S_DECIDE: begin
                    if (!toggled) begin
                        ok_d    = 1'b1;
                        state_d = S_REPORT;
                    end else if (confirm_q) begin
                        ok_d    = 1'b0;
                        state_d = S_RESET_CMD;
                    end else if (timeout_seen) begin
                        confirm_d = 1'b1;
                        state_d   = S_READ_A;
                    end else if (last_pair) begin
                        ok_d    = 1'b0;
                        state_d = S_RESET_CMD;
                    end else begin
                        cnt_inc = 1'b1;
                        state_d = S_READ_A;
                    end
                end
                S_RESET_CMD: begin
                    if (wr_ack) begin
                        state_d = S_REPORT;
                    end
                end
                S_REPORT: begin
                    state_d = S_IDLE;
                end
                default: begin
                    state_d = S_IDLE;
                end
            endcase
        end
    end

    // Output logic
    always_comb begin
        rd_req  = 1'b0;
        wr_req  = 1'b0;
        wr_data = '0;
        done    = 1'b0;
        pass    = 1'b0;
        busy    = 1'b1;
        unique case (state_q)
            S_IDLE:      busy = 1'b0;
            S_READ_A,
            S_READ_B:    rd_req = 1'b1;
            S_DECIDE:    ;
            S_RESET_CMD: begin
                wr_req  = 1'b1;
                wr_data = CMD_WORD;
            end
            S_REPORT: begin
                done = 1'b1;
                pass = ok_q;
            end
            default:     busy = 1'b0;
        endcase
    end

endmodule

// File: rtl/tp_checker.sv
module tp_checker (
    input logic clk,
    input logic rst_n,
    input logic abort,
    input logic rd_req,
    input logic rd_valid,
    input logic wr_req,
    input logic wr_ack,
    input logic busy,
    input logic done,
    input logic pass
);

    AST_PASS_ONLY_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n) pass |-> done); // R8
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
    AST_BUSY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n) done |-> busy); // R1
    AST_RD_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n) (rd_req && !rd_valid && !abort) |=> rd_req); // R9
    AST_WR_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n) (wr_req && !wr_ack && !abort) |=> wr_req); // R5
    AST_NO_RD_WITH_WR: assert property (@(posedge clk) disable iff (!rst_n) !(rd_req && wr_req)); // R5
    AST_FAIL_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (wr_req && wr_ack && !abort) |=> (done && !pass)); // R5
    AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (busy && abort) |=> (!busy && !done)); // R7

endmodule

bind toggle_poller tp_checker u_tp_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .abort   (abort),
    .rd_req  (rd_req),
    .rd_valid(rd_valid),
    .wr_req  (wr_req),
    .wr_ack  (wr_ack),
    .busy    (busy),
    .done    (done),
    .pass    (pass)
);

// File: tb/tb_toggle_poller.sv
module tb_toggle_poller;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       abort = 1'b0;
    logic [7:0] poll_limit = 8'd0;
    logic       rd_req, wr_req, busy, done, pass;
    logic       rd_valid = 1'b0;
    logic [7:0] rd_data = 8'h00;
    logic [7:0] wr_data;
    logic       wr_ack = 1'b0;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    toggle_poller dut (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
        .poll_limit(poll_limit), .rd_req(rd_req), .rd_valid(rd_valid),
        .rd_data(rd_data), .wr_req(wr_req), .wr_data(wr_data),
        .wr_ack(wr_ack), .busy(busy), .done(done), .pass(pass)
    );

    // Flash status model: one word per requested read, acks every write.
    logic [7:0] words [16];
    int nw = 0;
    int base = 0;
    int idx = 0;
    int wcnt = 0;
    logic [7:0] last_wd = 8'h00;

    always @(negedge clk) begin
        if (rd_req) begin
            rd_valid <= 1'b1;
            rd_data  <= ((idx - base) < nw) ? words[idx - base] : 8'h00;
            idx      <= idx + 1;
        end else begin
            rd_valid <= 1'b0;
        end
        wr_ack <= wr_req;
        if (wr_req) begin
            wcnt    <= wcnt + 1;
            last_wd <= wr_data;
        end
    end

    // Vector table: up to 8 status words (first in bits 63:56), word count,
    // limit, expected pass, reads, writes, requirement tag.
    localparam int NV = 7;
    localparam logic [63:0] VW [NV] = '{
        64'h0000_0000_0000_0000,
        64'h0040_4040_0000_0000,
        64'h0060_6060_0000_0000,
        64'h0060_2060_0000_0000,
        64'h0040_0040_0000_0000,
        64'h2040_4040_0000_0000,
        64'h0040_0040_0040_4040
    };
    localparam int VN   [NV] = '{2, 4, 4, 4, 4, 4, 8};
    localparam int VLIM [NV] = '{0, 0, 0, 0, 2, 0, 0};
    localparam bit VPASS[NV] = '{1, 1, 1, 0, 0, 1, 1};
    localparam int VRD  [NV] = '{2, 4, 4, 4, 4, 4, 8};
    localparam int VWR  [NV] = '{0, 0, 0, 1, 1, 0, 0};
    localparam string VTAG[NV] = '{"R2", "R3", "R4", "R5", "R6", "R3", "R6"};

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic check(input string tag, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic load(input logic [63:0] w, input int n);
        for (int i = 0; i < 8; i++) words[i] = w[63-8*i -: 8];
        nw   = n;
        base = idx;
    endtask

    task automatic pulse_start();
        start = 1'b1;
        step();
        start = 1'b0;
    endtask

    task automatic run_case(input string tag, input bit exp_pass, input int exp_rd, input int exp_wr);
        int w0;
        int guard;
        w0 = wcnt;
        pulse_start();
        check("R1", "busy after start", busy, 1);
        guard = 0;
        while (!done && guard < 500) begin
            step();
            guard++;
        end
        check(tag, "done seen", done, 1);
        check(tag, "pass", pass, exp_pass);
        check(tag, "reads", idx - base, exp_rd);
        check("R5", "writes before done", wcnt - w0, exp_wr);
        if (exp_wr > 0) check("R5", "write data", last_wd, 8'hF0);
        step();
        check("R8", "done one cycle", done, 0);
        check("R8", "pass low after done", pass, 0);
        check("R1", "busy low after done", busy, 0);
        check(tag, "no read after result", idx - base, exp_rd);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) step();
        check("R8", "reset busy", busy, 0);
        check("R8", "reset done", done, 0);
        check("R8", "reset rd_req", rd_req, 0);
        check("R8", "reset wr_req", wr_req, 0);
        rst_n = 1'b1;
        step();

        for (int v = 0; v < NV; v++) begin
            load(VW[v], VN[v]);
            poll_limit = 8'(VLIM[v]);
            run_case(VTAG[v], VPASS[v], VRD[v], VWR[v]);
            step();
        end

        // R7: abort during a confirming pair, then restart from the top.
        poll_limit = 8'd0;
        load(64'h0060_0000_0000_0000, 8);
        pulse_start();
        while ((idx - base) < 3) step();
        abort = 1'b1;
        step();
        abort = 1'b0;
        check("R7", "busy cleared by abort", busy, 0);
        check("R7", "no done on abort", done, 0);
        repeat (3) step();
        check("R7", "stays idle", busy, 0);
        load(64'h0040_4040_0000_0000, 4);
        run_case("R7", 1'b1, 4, 0);

        // R9: the read request is held while the word is withheld.
        load(64'h0000_0000_0000_0000, 2);
        force rd_valid = 1'b0;
        pulse_start();
        repeat (5) step();
        check("R9", "rd_req held without valid", rd_req, 1);
        check("R9", "still busy", busy, 1);
        release rd_valid;
        begin
            int guard = 0;
            while (!done && guard < 100) begin
                step();
                guard++;
            end
        end
        check("R9", "completes after valid", done && pass, 1);
        step();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule